// File: doc/BRIEF.md
# Power Domain Power-Up Sequencer

This block brings one switchable power domain from fully off to fully on. It drives the domain's control word through a fixed series of steps. First it turns on the primary power switch, then the secondary switch. It waits until both power-good inputs report the rail is up. It then ungates the clock, drops isolation and releases the domain reset, each in its own cycle. Next it powers up every SRAM bank and waits until the selected bank acknowledge inputs have all returned to zero. Only then does it raise its done flag.

Software cannot start a sequence by accident. Before a start strobe has any effect, a configuration write must carry the correct 16-bit key and have its enable bit set. An optional watchdog limit raises a sticky error flag if any wait takes too long. The sequence itself keeps waiting when this happens. The parameter `ACK_W` picks which acknowledge bits the sequencer checks: 1 means only the lowest bank bit, 4 means all four bits. This lets the same module serve domains with one SRAM bank and domains with four.

Top module: `pwrseq_top`

## Requirements
- R1: Out of reset, `ctrl_word[11:0]` reads 0xF12: reset bit 0 is low, isolation bit 1 is high, enables bits 2 and 3 are low, clock disable bit 4 is high, bits 6:5 are low, and SRAM power-down bits 11:8 are all high. `done` and `err` are low.
- R2: A write arms the unit only when `cfg_wr_data[31:16]` equals `KEY` and `cfg_wr_data[0]` is 1. Any other write is ignored. A `start` given while the unit is not armed changes nothing. Each accepted start uses up the arming.
- R3: On the clock edge that accepts a start, primary enable bit 2 sets. On the next edge, secondary enable bit 3 sets.
- R4: After both enables are set, the sequencer holds until `pg_pri` and `pg_sec` are both high at a clock edge. On that edge, clock disable bit 4 clears.
- R5: On the next three successive edges, isolation bit 1 clears, reset bit 0 sets, and then SRAM power-down bits 11:8 all clear. No two of these steps share a cycle.
- R6: From the edge after the SRAM bits clear, `done` rises on the first edge at which the checked acknowledge bits are all zero.
- R7: With `ACK_W`=1, only `sram_ack[0]` gates completion. With `ACK_W`=4, all four bits gate it.
- R8: `done` stays high until the next accepted start, which clears it. A start while a sequence is running is ignored, even if the unit is armed.
- R9: When `to_limit` is nonzero and a power-good wait or an acknowledge wait lasts more than `to_limit` cycles, `err` goes high. It stays high until the next accepted start. When `to_limit` is zero, `err` never rises.
- R10: `ctrl_word[15:12]` reads back `sram_ack` masked to the checked bits, and bits 6:5 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 32 | Configuration word: key in 31:16, arm bit 0 |
| start | input | 1 | Start strobe |
| pg_pri | input | 1 | Primary power-good status |
| pg_sec | input | 1 | Secondary power-good status |
| sram_ack | input | 4 | SRAM bank acknowledge; high means the bank is not ready |
| to_limit | input | TW | Wait limit in cycles; 0 disables the watchdog |
| ctrl_word | output | 16 | Domain control word |
| done | output | 1 | Sequence complete |
| err | output | 1 | Sticky wait-timeout flag |

## Verification
The bench sweeps the cycle at which power-good arrives against the cycle at which the acknowledges clear, and checks the whole control word on every cycle. Both edges of that sweep matter: power-good arriving before the enables are even set, and acknowledges clearing before the SRAM banks are powered. A design that skipped the power-good wait, merged two steps into one cycle, or finished before powering the banks would show the wrong word in some cycle.

A second instance with the narrow mask sees acknowledges stuck high on the upper banks. A design that ignored the mask would hang there, and one that ignored the acknowledges entirely would finish early. The bench also tries a wrong key, a missing arm bit, a start during a running sequence, and short and long waits under a limit. A broken design would wrongly start on the bad writes, restart mid-sequence, or flag a timeout too early or not at all.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_SEC, S_WPG, S_ISO, S_RST, S_SRAM, S_WACK, S_DONE
  } seq_state_t;

  localparam int B_RSTN = 0;
  localparam int B_ISO  = 1;
  localparam int B_PRI  = 2;
  localparam int B_SEC  = 3;
  localparam int B_CKD  = 4;
  localparam int BANKS  = 4;
endpackage

// File: rtl/pwrseq_unlock.sv
module pwrseq_unlock #(
  parameter logic [15:0] KEY = 16'hA5C3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        consume,
  output logic        armed
);
  logic key_ok;
  assign key_ok = wr_en && (wr_data[31:16] == KEY) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed <= 1'b0;
    else if (key_ok)  armed <= 1'b1;
    else if (consume) armed <= 1'b0;
  end
endmodule

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          waiting,
  input  logic [TW-1:0] limit,
  input  logic          clr,
  output logic          err
);
  logic [TW-1:0] cnt;
  logic          expired;

  assign expired = waiting && (limit != '0) && (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!waiting)      cnt <= '0;
    else if (cnt != '1)     cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err <= 1'b0;
    else if (clr)     err <= 1'b0;
    else if (expired) err <= 1'b1;
  end
endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_req,
  input  logic       pg_ok,
  input  logic       ack_ok,
  output logic       go,
  output logic       waiting,
  output logic [4:0] ctl,
  output logic [3:0] pdn,
  output logic       done
);
  seq_state_t st;

  assign go      = go_req && (st == S_IDLE || st == S_DONE);
  assign waiting = (st == S_WPG) || (st == S_WACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      ctl  <= 5'b1_0010;
      pdn  <= '1;
      done <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE, S_DONE: if (go) begin
          ctl[B_PRI] <= 1'b1;
          done       <= 1'b0;
          st         <= S_SEC;
        end
        S_SEC: begin
          ctl[B_SEC] <= 1'b1;
          st         <= S_WPG;
        end
        S_WPG: if (pg_ok) begin
          ctl[B_CKD] <= 1'b0;
          st         <= S_ISO;
        end
        S_ISO: begin
          ctl[B_ISO] <= 1'b0;
          st         <= S_RST;
        end
        S_RST: begin
          ctl[B_RSTN] <= 1'b1;
          st          <= S_SRAM;
        end
        S_SRAM: begin
          pdn <= '0;
          st  <= S_WACK;
        end
        S_WACK: if (ack_ok) begin
          done <= 1'b1;
          st   <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
  import pwrseq_pkg::*;
#(
  parameter logic [15:0] KEY   = 16'hA5C3,
  parameter int          ACK_W = 4,
  parameter int          TW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr_en,
  input  logic [31:0]   cfg_wr_data,
  input  logic          start,
  input  logic          pg_pri,
  input  logic          pg_sec,
  input  logic [3:0]    sram_ack,
  input  logic [TW-1:0] to_limit,
  output logic [15:0]   ctrl_word,
  output logic          done,
  output logic          err
);
  logic [BANKS-1:0] ack_mask;
  logic [BANKS-1:0] ack_view;
  logic       armed, go, waiting;
  logic [4:0] ctl;
  logic [3:0] pdn;

  generate
    if (ACK_W == 1) begin : g_one
      assign ack_mask = 4'b0001;
    end else begin : g_all
      assign ack_mask = 4'b1111;
    end
  endgenerate

  assign ack_view = sram_ack & ack_mask;

  pwrseq_unlock #(.KEY(KEY)) u_unlock (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .consume(go), .armed(armed)
  );

  pwrseq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .go_req(start && armed),
    .pg_ok(pg_pri && pg_sec), .ack_ok(ack_view == '0),
    .go(go), .waiting(waiting), .ctl(ctl), .pdn(pdn), .done(done)
  );

  pwrseq_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .waiting(waiting), .limit(to_limit),
    .clr(go), .err(err)
  );

  assign ctrl_word = {ack_view, pdn, 3'b000, ctl};
endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk #(
  parameter int ACK_W = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        pg_pri,
  input logic        pg_sec,
  input logic [3:0]  sram_ack,
  input logic [15:0] ctrl_word,
  input logic        done
);
  logic [3:0] m;
  assign m = (ACK_W == 1) ? 4'b0001 : 4'b1111;

  AST_SEC_AFTER_PRI: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_word[3]) |-> $past(ctrl_word[2])); // R3
  AST_PG_BEFORE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_word[4]) |-> $past(pg_pri && pg_sec)); // R4
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ctrl_word[4:0] ^ $past(ctrl_word[4:0])) <= 1); // R5
  AST_RST_AFTER_ISO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_word[0]) |-> (!ctrl_word[1] && !ctrl_word[4])); // R5
  AST_DONE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (($past(sram_ack) & m) == 4'b0000 && ctrl_word[11:8] == 4'b0000)); // R6
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R8
endmodule

bind pwrseq_top pwrseq_chk #(.ACK_W(ACK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .pg_pri(pg_pri), .pg_sec(pg_sec),
  .sram_ack(sram_ack), .ctrl_word(ctrl_word), .done(done)
);

// File: tb/pwrseq_top_tb.sv
module pwrseq_top_tb;
  localparam logic [15:0] KEY = 16'hA5C3;
  logic clk = 0, rst_n = 0, cfg_wr_en = 0, start = 0, pg_pri = 0, pg_sec = 0;
  logic [31:0] cfg_wr_data = '0;
  logic [3:0]  sram_ack = 4'hF;
  logic [15:0] to_limit = '0;
  logic [15:0] cw, cw1;
  logic done, err, done1, err1;
  int vecs = 0, bad = 0, cyc = 0;

  always #5 clk = ~clk;

  pwrseq_top #(.KEY(KEY), .ACK_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .start(start), .pg_pri(pg_pri), .pg_sec(pg_sec), .sram_ack(sram_ack),
    .to_limit(to_limit), .ctrl_word(cw), .done(done), .err(err));
  pwrseq_top #(.KEY(KEY), .ACK_W(1)) u_dut1 (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .start(start), .pg_pri(pg_pri), .pg_sec(pg_sec), .sram_ack(sram_ack),
    .to_limit(to_limit), .ctrl_word(cw1), .done(done1), .err(err1));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1;
      $display("FAIL watchdog: act=%0d exp<=150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; start = 0; cfg_wr_en = 0; pg_pri = 0; pg_sec = 0; sram_ack = 4'hF;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic arm(logic [31:0] w);
    cfg_wr_en = 1; cfg_wr_data = w;
    @(negedge clk);
    cfg_wr_en = 0;
  endtask

  function automatic logic [11:0] exp_lo(int n, int G);
    logic [11:0] v = 12'hF12;
    if (n >= 1)     v[2] = 1'b1;
    if (n >= 2)     v[3] = 1'b1;
    if (n >= G)     v[4] = 1'b0;
    if (n >= G + 1) v[1] = 1'b0;
    if (n >= G + 2) v[0] = 1'b1;
    if (n >= G + 3) v[11:8] = 4'h0;
    return v;
  endfunction

  // g: edge before which power-good is high; a: edge before which ack takes ack_after
  task automatic run_seq(int g, int a, logic [3:0] ack_after, bit poke, int lim);
    int G = (g > 3) ? g : 3;
    int D = (G + 4 > a) ? G + 4 : a;
    int N = (ack_after == 0) ? D + 3 : G + 9;
    bit exp_err;
    do_reset();
    to_limit = lim[15:0];
    chk("R1 reset word", {20'h0, cw[11:0]}, 32'hF12);
    chk("R1 reset done/err", {done, err}, 0);
    arm({KEY, 16'h0001});
    start = 1;
    pg_pri = (g <= 1); pg_sec = (g <= 1);
    sram_ack = (a <= 1) ? ack_after : 4'hF;
    for (int n = 1; n <= N; n++) begin
      @(negedge clk);
      start = 0; cfg_wr_en = 0;
      if (poke && n == 3) begin cfg_wr_en = 1; cfg_wr_data = {KEY, 16'h0001}; end
      if (poke && n == 4) start = 1;
      pg_pri = (n + 1 >= g); pg_sec = (n + 1 >= g);
      sram_ack = (n + 1 >= a) ? ack_after : 4'hF;
      #1;
      chk(poke ? "R8 busy start / R3 R4 R5 word" : "R3 R4 R5 word",
          {20'h0, cw[11:0]}, {20'h0, exp_lo(n, G)});
      chk("R10 ack view", {28'h0, cw[15:12]}, {28'h0, sram_ack});
      chk("R6 done", {31'h0, done}, {31'h0, (ack_after == 0 && n >= D)});
      chk("R7 narrow done", {31'h0, done1}, {31'h0, (ack_after[0] == 0 && n >= D)});
      chk("R10 narrow view", {28'h0, cw1[15:12]}, {28'h0, 3'b000, sram_ack[0]});
    end
    if (ack_after == 0) begin
      exp_err = (lim != 0) && ((G - 2 > lim) || (D - G - 3 > lim));
      chk("R9 timeout", {31'h0, err}, {31'h0, exp_err});
    end
  endtask

  initial begin
    // R3 R4 R5 R6 R10: sweep power-good and acknowledge arrival
    for (int g = 1; g <= 6; g++)
      for (int a = 1; a <= 12; a++)
        run_seq(g, a, 4'h0, 1'b0, 0);
    // R7: upper banks stuck, narrow instance finishes, wide one waits
    run_seq(4, 2, 4'b1110, 1'b0, 0);
    run_seq(5, 9, 4'b0001, 1'b0, 0);
    // R9: short waits, long pg wait, long ack wait, disabled limit
    run_seq(4, 3, 4'h0, 1'b0, 4);
    run_seq(12, 3, 4'h0, 1'b0, 4);
    run_seq(3, 20, 4'h0, 1'b0, 4);
    run_seq(12, 20, 4'h0, 1'b0, 0);
    // R8: start during a running sequence, armed, is ignored
    run_seq(8, 1, 4'h0, 1'b1, 0);
    // R8: done holds, then the leftover arming accepts a restart
    repeat (5) @(negedge clk);
    #1 chk("R8 done holds", {31'h0, done}, 1);
    start = 1;
    @(negedge clk); start = 0; #1;
    chk("R8 restart clears done", {31'h0, done}, 0);
    chk("R2 restart keeps pri", {31'h0, cw[2]}, 1);
    // R2: bad key, missing arm bit, start without arming
    do_reset();
    arm({KEY ^ 16'h0100, 16'h0001});
    arm({KEY, 16'h0000});
    start = 1;
    @(negedge clk); start = 0;
    repeat (5) @(negedge clk);
    #1 chk("R2 locked word", {20'h0, cw[11:0]}, 32'hF12);
    chk("R2 locked done", {31'h0, done}, 0);
    // R2: arming used up by one start
    do_reset();
    pg_pri = 1; pg_sec = 1; sram_ack = 0;
    arm({KEY, 16'h0001});
    start = 1; @(negedge clk); start = 0;
    repeat (10) @(negedge clk);
    #1 chk("R2 armed run done", {31'h0, done}, 1);
    start = 1; @(negedge clk); start = 0; #1;
    chk("R2 arming consumed", {31'h0, done}, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule